// File: doc/BRIEF.md
# Serial Bitstream Configuration Loader

This block loads a configuration bitstream into a downstream programmable device through its slave-serial port. A host pulses `start_i` together with the total byte count. The loader then emits a one-cycle pre-configuration hook pulse and pulls the program line low. It waits for the device to report that its configuration memory is clearing (init low), releases program, and waits for the device to become ready (init high).

Bytes then arrive on a valid/ready stream. Each byte is sent most significant bit first. Every bit takes three pin phases: configuration clock low, data presented, configuration clock high. Each phase lasts `DIV` system clocks, so the device samples the stable data on the rising clock edge. Before each byte the loader checks for the device's error indication. After the last byte it holds the data line high and keeps pulsing the clock until the device raises done.

Every waiting phase has a timeout counted in system clocks. Each failure reports its own code. The init and done inputs pass through two-flop synchronizers before the loader makes any decision on them.

Top module: `cfgld_loader`

## Requirements
- R1: After reset, prog_n_o=1, cclk_o=0, sdata_o=1, busy_o=0, ok_o=0, err_o=0, byte_ready_o=0 and pre_hook_o=0.
- R2: A start_i pulse seen while idle sets busy_o one cycle later. pre_hook_o pulses for exactly one cycle, and prog_n_o falls in the very next cycle. A start_i pulse while busy is ignored.
- R3: prog_n_o stays low until the synchronized init_n_i is seen low, then returns high. If init_n_i is not seen low within TMO cycles, the run ends with err_o=1.
- R4: After program is released, the loader waits for init_n_i to go high. If it is not seen high within TMO cycles, the run ends with err_o=2.
- R5: Each byte is shifted most significant bit first, 8 bits per byte. For each bit, cclk_o is low for DIV cycles, then sdata_o carries the bit for DIV cycles, then cclk_o is high for DIV cycles. sdata_o is stable across every rising edge of cclk_o.
- R6: byte_ready_o is high only while byte_valid_i is high and the shifter is between bytes. It is high for exactly one cycle per accepted byte, and exactly total_bytes_i bytes are accepted on a successful run.
- R7: Before each byte, if the synchronized init_n_i is low while done_i is low, the run ends with err_o=3 and no further byte is accepted.
- R8: After the last byte, sdata_o is held at 1 and cclk_o keeps toggling until done_i is seen high. The run then ends with ok_o=1 and err_o=0.
- R9: If done_i is not seen high within TMO cycles of the tail clocking, the run ends with err_o=4.
- R10: ok_o and err_o are never both set. Each result is held, with busy_o low, until the next start. A load of zero bytes goes straight from the init handshake to the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| total_bytes_i | input | CNT_W | Number of bitstream bytes, sampled at start |
| byte_data_i | input | 8 | Bitstream byte |
| byte_valid_i | input | 1 | Byte on byte_data_i is valid |
| byte_ready_o | output | 1 | Byte accepted this cycle |
| init_n_i | input | 1 | Device init status, active low, asynchronous |
| done_i | input | 1 | Device done status, asynchronous |
| prog_n_o | output | 1 | Program line to the device, active low |
| cclk_o | output | 1 | Configuration clock to the device |
| sdata_o | output | 1 | Serial configuration data |
| pre_hook_o | output | 1 | One-cycle pulse before program is asserted |
| busy_o | output | 1 | A load is in progress |
| ok_o | output | 1 | Last load completed successfully |
| err_o | output | 3 | Failure code of last load: 0 none, 1 init-start timeout, 2 init-clear timeout, 3 CRC error, 4 done timeout |

## Verification
busy_o is due one cycle after the start edge, and the bench samples it at the following falling edge. The hook pulse must sit exactly one cycle before program falls, and the bench checks this on every clock. Bits are taken at each rising cclk_o, as a device would, and compared in order against a queue built from the bytes sent; tail bits must be ones. Each run's result is read once busy_o falls. Timeout runs must last between TMO and TMO plus a few cycles for the synchronizer and the handshake states.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOOK,
    ST_PROG,
    ST_INITREL,
    ST_BYTE,
    ST_BIT,
    ST_TAIL
  } ld_state_t;

  typedef enum logic [1:0] {
    PH_LOW,
    PH_DATA,
    PH_HIGH
  } pin_phase_t;

  localparam logic [2:0] ERR_NONE      = 3'd0;
  localparam logic [2:0] ERR_INIT_LOW  = 3'd1;
  localparam logic [2:0] ERR_INIT_HIGH = 3'd2;
  localparam logic [2:0] ERR_CRC       = 3'd3;
  localparam logic [2:0] ERR_DONE      = 3'd4;

endpackage

// File: rtl/cfgld_sync.sv
module cfgld_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_r [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_r[0] <= RST_VAL;
          else     stage_r[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_r[s] <= RST_VAL;
          else     stage_r[s] <= stage_r[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_r[STAGES-1];
endmodule

// File: rtl/cfgld_pacer.sv
module cfgld_pacer #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_r;

  assign tick = (cnt_r == LAST);

  always_ff @(posedge clk) begin
    if (rst || hold) cnt_r <= '0;
    else if (tick)   cnt_r <= '0;
    else             cnt_r <= cnt_r + 1'b1;
  end
endmodule

// File: rtl/cfgld_loader.sv
module cfgld_loader
  import cfgld_pkg::*;
#(
  parameter int DIV   = 4,
  parameter int TMO   = 100000,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CNT_W-1:0] total_bytes_i,
  input  logic [7:0]       byte_data_i,
  input  logic             byte_valid_i,
  output logic             byte_ready_o,
  input  logic             init_n_i,
  input  logic             done_i,
  output logic             prog_n_o,
  output logic             cclk_o,
  output logic             sdata_o,
  output logic             pre_hook_o,
  output logic             busy_o,
  output logic             ok_o,
  output logic [2:0]       err_o
);
  localparam int            TW       = $clog2(TMO + 1);
  localparam logic [TW-1:0] TMO_LAST = TW'(TMO - 1);

  ld_state_t        state_r;
  pin_phase_t       phase_r;
  logic [TW-1:0]    tmo_r;
  logic [CNT_W-1:0] left_r;
  logic [7:0]       shreg_r;
  logic [2:0]       bit_r;
  logic             init_n_s, done_s;
  logic             tick, pace_hold;
  logic             crc_hit, tmo_hit;

  cfgld_sync #(.W(2), .STAGES(2), .RST_VAL(2'b01)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({done_i, init_n_i}),
    .q   ({done_s, init_n_s})
  );

  assign pace_hold = (state_r != ST_BIT) && (state_r != ST_TAIL);

  cfgld_pacer #(.DIV(DIV)) u_pacer (
    .clk  (clk),
    .rst  (rst),
    .hold (pace_hold),
    .tick (tick)
  );

  assign crc_hit      = !init_n_s && !done_s;
  assign tmo_hit      = (tmo_r == TMO_LAST);
  assign byte_ready_o = (state_r == ST_BYTE) && byte_valid_i &&
                        (left_r != '0) && !crc_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_r    <= ST_IDLE;
      phase_r    <= PH_LOW;
      tmo_r      <= '0;
      left_r     <= '0;
      shreg_r    <= '0;
      bit_r      <= '0;
      prog_n_o   <= 1'b1;
      cclk_o     <= 1'b0;
      sdata_o    <= 1'b1;
      pre_hook_o <= 1'b0;
      busy_o     <= 1'b0;
      ok_o       <= 1'b0;
      err_o      <= ERR_NONE;
    end else begin
      pre_hook_o <= 1'b0;
      case (state_r)
        ST_IDLE: begin
          if (start_i) begin
            busy_o     <= 1'b1;
            ok_o       <= 1'b0;
            err_o      <= ERR_NONE;
            pre_hook_o <= 1'b1;
            left_r     <= total_bytes_i;
            cclk_o     <= 1'b0;
            sdata_o    <= 1'b1;
            state_r    <= ST_HOOK;
          end
        end
        ST_HOOK: begin
          prog_n_o <= 1'b0;
          tmo_r    <= '0;
          state_r  <= ST_PROG;
        end
        ST_PROG: begin
          if (!init_n_s) begin
            prog_n_o <= 1'b1;
            tmo_r    <= '0;
            state_r  <= ST_INITREL;
          end else if (tmo_hit) begin
            prog_n_o <= 1'b1;
            busy_o   <= 1'b0;
            err_o    <= ERR_INIT_LOW;
            state_r  <= ST_IDLE;
          end else begin
            tmo_r <= tmo_r + 1'b1;
          end
        end
        ST_INITREL: begin
          if (init_n_s) begin
            tmo_r   <= '0;
            state_r <= ST_BYTE;
          end else if (tmo_hit) begin
            busy_o  <= 1'b0;
            err_o   <= ERR_INIT_HIGH;
            state_r <= ST_IDLE;
          end else begin
            tmo_r <= tmo_r + 1'b1;
          end
        end
        ST_BYTE: begin
          if (crc_hit) begin
            busy_o  <= 1'b0;
            err_o   <= ERR_CRC;
            state_r <= ST_IDLE;
          end else if (left_r == '0) begin
            sdata_o <= 1'b1;
            cclk_o  <= 1'b0;
            phase_r <= PH_LOW;
            tmo_r   <= '0;
            state_r <= ST_TAIL;
          end else if (byte_valid_i) begin
            shreg_r <= byte_data_i;
            bit_r   <= 3'd7;
            left_r  <= left_r - 1'b1;
            cclk_o  <= 1'b0;
            phase_r <= PH_LOW;
            state_r <= ST_BIT;
          end
        end
        ST_BIT: begin
          if (tick) begin
            case (phase_r)
              PH_LOW: begin
                sdata_o <= shreg_r[7];
                phase_r <= PH_DATA;
              end
              PH_DATA: begin
                cclk_o  <= 1'b1;
                phase_r <= PH_HIGH;
              end
              default: begin
                shreg_r <= {shreg_r[6:0], 1'b0};
                if (bit_r == 3'd0) begin
                  state_r <= ST_BYTE;
                end else begin
                  bit_r   <= bit_r - 1'b1;
                  cclk_o  <= 1'b0;
                  phase_r <= PH_LOW;
                end
              end
            endcase
          end
        end
        ST_TAIL: begin
          if (done_s) begin
            ok_o    <= 1'b1;
            busy_o  <= 1'b0;
            state_r <= ST_IDLE;
          end else if (tmo_hit) begin
            busy_o  <= 1'b0;
            err_o   <= ERR_DONE;
            state_r <= ST_IDLE;
          end else begin
            tmo_r <= tmo_r + 1'b1;
            if (tick) begin
              cclk_o  <= (phase_r == PH_LOW);
              phase_r <= (phase_r == PH_LOW) ? PH_HIGH : PH_LOW;
            end
          end
        end
        default: state_r <= ST_IDLE;
      endcase
    end
  end

  AST_HOOK_BEFORE_PROG: assert property (@(posedge clk) disable iff (rst)
    $fell(prog_n_o) |-> $past(pre_hook_o)); // R2
  AST_HOOK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pre_hook_o |=> !pre_hook_o); // R2
  AST_NO_CLOCK_IN_PROG: assert property (@(posedge clk) disable iff (rst)
    !prog_n_o |-> !cclk_o); // R3
  AST_DATA_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(cclk_o) |-> $stable(sdata_o)); // R5
  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (rst)
    byte_ready_o |=> !byte_ready_o); // R6
  AST_SUCCESS_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(ok_o) |-> !busy_o); // R8
  AST_RESULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(ok_o && (err_o != ERR_NONE))); // R10
endmodule

// File: tb/test_cfgld_loader.sv
module test_cfgld_loader;
  localparam int DIV = 2;
  localparam int TMO = 300;
  localparam int CW  = 16;

  localparam int M_GOOD = 0, M_NO_INIT = 1, M_STUCK = 2, M_CRC = 3, M_NO_DONE = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic start_i = 1'b0;
  logic [CW-1:0] total_bytes_i = '0;
  logic [7:0] byte_data_i = '0;
  logic byte_valid_i = 1'b0;
  logic byte_ready_o, prog_n_o, cclk_o, sdata_o, pre_hook_o, busy_o, ok_o;
  logic [2:0] err_o;
  logic init_n_r = 1'b1, done_r = 1'b0;

  always #10 clk = ~clk;

  cfgld_loader #(.DIV(DIV), .TMO(TMO), .CNT_W(CW)) i_cfgld_loader (
    .clk(clk), .rst(rst), .start_i(start_i), .total_bytes_i(total_bytes_i),
    .byte_data_i(byte_data_i), .byte_valid_i(byte_valid_i),
    .byte_ready_o(byte_ready_o), .init_n_i(init_n_r), .done_i(done_r),
    .prog_n_o(prog_n_o), .cclk_o(cclk_o), .sdata_o(sdata_o),
    .pre_hook_o(pre_hook_o), .busy_o(busy_o), .ok_o(ok_o), .err_o(err_o)
  );

  int t_cmp = 0, t_bad = 0;
  int dev_cmp = 0, dev_bad = 0;
  int mon_cmp = 0, mon_bad = 0;
  int src_cmp = 0, src_bad = 0;

  int  dev_mode = M_GOOD;
  int  crc_bit  = 12;
  logic dev_clear = 1'b0;
  logic exp_bits[$];
  logic [7:0] src_q[$];
  int  accepted = 0, pre_count = 0, tail_ones = 0;
  logic gap_on = 1'b0;
  longint cyc = 0;

  // behavioural target device
  int  prog_lo = 0, rel_cnt = 0, bits_seen = 0, tail_rises = 0;
  logic cclk_q = 1'b0, prog_q = 1'b1;
  always @(posedge clk) begin
    cclk_q <= cclk_o;
    prog_q <= prog_n_o;
    if (dev_clear) begin
      init_n_r <= 1'b1; done_r <= 1'b0;
      prog_lo = 0; rel_cnt = 0; bits_seen = 0; tail_rises = 0;
    end else begin
      if (!prog_n_o) begin
        done_r <= 1'b0;
        prog_lo++;
        if (prog_lo >= 3 && dev_mode != M_NO_INIT) init_n_r <= 1'b0;
      end else begin
        prog_lo = 0;
        if (!init_n_r && dev_mode != M_STUCK && bits_seen == 0) begin
          rel_cnt++;
          if (rel_cnt >= 4) init_n_r <= 1'b1;
        end
      end
      if (cclk_o && !cclk_q) begin
        if (exp_bits.size() > 0) begin
          logic e;
          e = exp_bits.pop_front();
          dev_cmp++;
          if (sdata_o !== e) begin
            dev_bad++;
            $display("FAIL R5: bit %0d got %b exp %b", bits_seen, sdata_o, e);
          end
          bits_seen++;
          if (dev_mode == M_CRC && bits_seen == crc_bit) init_n_r <= 1'b0;
        end else begin
          dev_cmp++;
          if (sdata_o !== 1'b1) begin
            dev_bad++;
            $display("FAIL R8: tail data got %b exp 1", sdata_o);
          end else tail_ones++;
          tail_rises++;
          if (tail_rises >= 3 && dev_mode != M_NO_DONE) done_r <= 1'b1;
        end
      end
    end
  end

  // per-clock monitor
  logic prog_prev = 1'b1, pre_prev = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      mon_cmp++;
      if (!prog_n_o && prog_prev && !pre_prev) begin
        mon_bad++;
        $display("FAIL R2: prog fell without hook pulse before it (got 0 exp 1)");
      end
      mon_cmp++;
      if (!prog_n_o && cclk_o) begin
        mon_bad++;
        $display("FAIL R3: cclk high while program low (got 1 exp 0)");
      end
      if (pre_hook_o) pre_count++;
    end
    prog_prev = prog_n_o;
    pre_prev  = pre_hook_o;
  end

  // byte source: drives at negedge, records handshake just before posedge
  int gap_ph = 0;
  always @(negedge clk) begin
    gap_ph++;
    if (src_q.size() > 0 && !(gap_on && (gap_ph % 3 == 0))) begin
      byte_valid_i = 1'b1; byte_data_i = src_q[0];
    end else begin
      byte_valid_i = 1'b0; byte_data_i = 8'h00;
    end
    #8;
    if (byte_ready_o) begin
      src_cmp++;
      if (!byte_valid_i) begin
        src_bad++;
        $display("FAIL R6: ready without valid got 1 exp 0");
      end else begin
        void'(src_q.pop_front());
        accepted++;
      end
    end
  end

  task automatic check(input bit cond, input string req, input int got, input int expv);
    t_cmp++;
    if (!cond) begin
      t_bad++;
      $display("FAIL %s: got %0d exp %0d", req, got, expv);
    end
  endtask

  int dur;
  task automatic run_load(input logic [7:0] data[$], input int mode, input bit poke_start);
    @(negedge clk);
    dev_clear = 1'b1; dev_mode = mode;
    @(negedge clk);
    dev_clear = 1'b0;
    exp_bits.delete(); src_q.delete();
    foreach (data[i]) begin
      src_q.push_back(data[i]);
      for (int b = 7; b >= 0; b--) exp_bits.push_back(data[i][b]);
    end
    accepted = 0; pre_count = 0; tail_ones = 0;
    total_bytes_i = CW'(data.size());
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o === 1'b1, "R2 busy after start", busy_o, 1);
    dur = 1;
    while (busy_o && dur < 20000) begin
      @(negedge clk);
      dur++;
      if (poke_start && dur == 40) start_i = 1'b1;
      if (poke_start && dur == 41) start_i = 1'b0;
    end
  endtask

  logic [7:0] d5[$] = '{8'hA5, 8'h3C, 8'hFF, 8'h00, 8'h81};
  logic [7:0] d4[$] = '{8'h12, 8'h34, 8'h56, 8'h78};
  logic [7:0] d1[$] = '{8'h01};
  logic [7:0] d0[$];

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(prog_n_o === 1'b1 && cclk_o === 1'b0 && sdata_o === 1'b1, "R1 pins", {prog_n_o, cclk_o, sdata_o}, 3'b101);
    check(busy_o === 0 && ok_o === 0 && err_o === 0, "R1 status", {busy_o, ok_o, err_o}, 0);
    check(byte_ready_o === 0 && pre_hook_o === 0, "R1 ready/hook", {byte_ready_o, pre_hook_o}, 0);

    // normal load with gaps and a start pulse while busy
    gap_on = 1'b1;
    run_load(d5, M_GOOD, 1'b1);
    check(ok_o === 1 && err_o === 0, "R8 success", {ok_o, err_o}, 8);
    check(accepted == 5, "R6 bytes accepted", accepted, 5);
    check(exp_bits.size() == 0, "R5 all bits shifted", exp_bits.size(), 0);
    check(tail_ones >= 1, "R8 tail ones", tail_ones, 1);
    check(pre_count == 1, "R2 one hook, start while busy ignored", pre_count, 1);
    repeat (20) @(negedge clk);
    check(ok_o === 1 && err_o === 0 && busy_o === 0, "R10 result held", {busy_o, ok_o, err_o}, 8);
    gap_on = 1'b0;

    // zero-length load
    run_load(d0, M_GOOD, 1'b0);
    check(ok_o === 1 && accepted == 0, "R10 zero bytes", accepted, 0);

    // init never drops
    run_load(d4, M_NO_INIT, 1'b0);
    check(err_o === 3'd1 && ok_o === 0, "R3 init-start timeout code", err_o, 1);
    check(dur >= TMO && dur <= TMO + 10, "R3 timeout length", dur, TMO);
    check(accepted == 0, "R3 no bytes taken", accepted, 0);

    // init never releases
    run_load(d4, M_STUCK, 1'b0);
    check(err_o === 3'd2, "R4 init-clear timeout code", err_o, 2);
    check(dur >= TMO && dur <= TMO + 16, "R4 timeout length", dur, TMO);

    // crc error during byte 1
    crc_bit = 12;
    run_load(d4, M_CRC, 1'b0);
    check(err_o === 3'd3 && ok_o === 0, "R7 crc code", err_o, 3);
    check(accepted == 2, "R7 bytes before abort", accepted, 2);

    // done never rises
    run_load(d1, M_NO_DONE, 1'b0);
    check(err_o === 3'd4 && ok_o === 0, "R9 done timeout code", err_o, 4);
    check(tail_ones >= 3, "R9 tail clocks ran", tail_ones, 3);

    // recovery after an error
    run_load(d1, M_GOOD, 1'b0);
    check(ok_o === 1 && err_o === 0, "R10 recover after error", {ok_o, err_o}, 8);
    check(exp_bits.size() == 0 && accepted == 1, "R5 single byte MSB first", accepted, 1);

    finish_run();
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***",
             t_cmp + dev_cmp + mon_cmp + src_cmp, t_bad + dev_bad + mon_bad + src_bad);
    $finish;
  endtask

  initial begin
    wait (cyc > 150000);
    t_cmp++; t_bad++;
    $display("FAIL watchdog: got %0d cycles exp fewer", cyc);
    finish_run();
  end
endmodule